// File: doc/BRIEF.md
# Bus-Off Supervisor

This block keeps the transmit error count of a node on a shared serial field bus. Each failed transmission adds a fixed penalty to the count, and each successful one takes a point away. When the count rises past its ceiling, the node drops off the bus: transmission is blocked and further error events are disregarded. The node then watches the bus to see that it has gone quiet before it may take part again.

To count as quiet, the bus must show a fixed number of runs of recessive bits, each run a fixed length. A dominant bit breaks the current run. Once the full quota of runs has been seen, one of two things happens, chosen by a mode input:

- the node returns to the error-active state on its own, or
- it parks in a waiting state until software asks for the release.

On release the error count and the run counters start again from zero. The surrounding controller supplies a sampled bus level together with a one-cycle strobe per bit time. It reads back a two-bit node state and a transmit-inhibit flag.

Top module: `busoff_supervisor`

## Requirements
- R1: After a synchronous reset, the node state is error-active (code 0) and tx_inhibit_o is low.
- R2: In the error-active state, err_inc_i raises the count by 8 and err_dec_i lowers it by 1. When both are high, only the raise is applied. The count never goes below 0 and saturates at its width limit.
- R3: The node state becomes bus-off (code 1) on the same clock edge that registers an event taking the count above 255. A count of exactly 255 does not cause bus-off.
- R4: While bus-off, each strobed recessive bit (bus_bit_i = 1) extends the current run. A run of 11 consecutive recessive bits credits one run and a new run begins. A strobed dominant bit (bus_bit_i = 0) discards the partial run.
- R5: The recovery sequence is complete after 128 credited runs. The node state leaves bus-off on the clock edge after the edge that registered the last bit of the 128th run.
- R6: With auto_rec_i high when the sequence completes, the node returns to error-active by itself.
- R7: With auto_rec_i low when the sequence completes, the node moves to the waiting state (code 2) with transmit still inhibited. From there it returns to error-active on the edge that samples rec_req_i high or auto_rec_i high.
- R8: A recovery request made before the sequence completes is ignored. It is not remembered and does not shorten the sequence.
- R9: Error events have no effect outside the error-active state. Bit strobes have no effect outside the bus-off state.
- R10: On each return to error-active, the error count and the run counters restart from zero, so exactly 32 raises lead to bus-off again.
- R11: tx_inhibit_o is high exactly when the node state is not error-active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| err_inc_i | input | 1 | Transmit error event, one per cycle high |
| err_dec_i | input | 1 | Successful transmission event |
| bus_bit_i | input | 1 | Sampled bus level, 1 = recessive |
| bit_strobe_i | input | 1 | One-cycle pulse marking a valid bus_bit_i |
| auto_rec_i | input | 1 | 1 = release by itself, 0 = wait for software |
| rec_req_i | input | 1 | Software release request |
| node_state_o | output | 2 | 0 error-active, 1 bus-off, 2 waiting for release |
| tx_inhibit_o | output | 1 | Transmit blocked |

## Verification
The assertions assume that every input is synchronous to clk and that bus_bit_i is valid whenever bit_strobe_i is high. They also assume that one strobe stands for one bit time, so a bit held for several strobes counts as several bits. The stimulus changes inputs only on the falling clock edge and gives each event or bit a single cycle. It releases reset only between scenarios, never in the middle of a run. Requests and mode changes are placed both before and after completion, so that the waiting state and the refusal of early releases are both reached.

// File: rtl/bor_pkg.sv
package bor_pkg;

  typedef enum logic [1:0] {
    NODE_ACTIVE  = 2'd0,
    NODE_BUSOFF  = 2'd1,
    NODE_WAITREL = 2'd2
  } node_state_t;

endpackage

// File: rtl/bor_err_counter.sv
module bor_err_counter #(
  parameter int LIMIT    = 255,
  parameter int INC_STEP = 8,
  parameter int DEC_STEP = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  input  logic clr_i,
  input  logic inc_i,
  input  logic dec_i,
  output logic ovf_next_o
);

  localparam int CNT_W = $clog2(LIMIT + INC_STEP + 1);
  localparam int MAXV  = (1 << CNT_W) - 1;

  logic [CNT_W-1:0] tec_q;
  logic [CNT_W-1:0] tec_d;
  logic [CNT_W:0]   sum;

  always_comb begin
    sum   = {1'b0, tec_q} + (CNT_W+1)'(INC_STEP);
    tec_d = tec_q;
    if (inc_i) begin
      tec_d = (sum > (CNT_W+1)'(MAXV)) ? CNT_W'(MAXV) : sum[CNT_W-1:0];
    end else if (dec_i) begin
      tec_d = (tec_q < CNT_W'(DEC_STEP)) ? '0 : tec_q - CNT_W'(DEC_STEP);
    end
  end

  assign ovf_next_o = en_i && (tec_d > CNT_W'(LIMIT));

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      tec_q <= '0;
    end else if (en_i) begin
      tec_q <= tec_d;
    end
  end

  // R9: count frozen while events are disabled
  a_r9_frozen: assert property (@(posedge clk) disable iff (rst)
    (!en_i && !clr_i) |=> $stable(tec_q));

  // R2: a lone decrement at zero stays at zero
  a_r2_floor: assert property (@(posedge clk) disable iff (rst)
    (en_i && !clr_i && tec_q == '0 && dec_i && !inc_i) |=> tec_q == '0);

  // R10: a clear request empties the count
  a_r10_clear: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> tec_q == '0);

endmodule

// File: rtl/bor_run_tracker.sv
module bor_run_tracker #(
  parameter int RUN_LEN    = 11,
  parameter int RUN_TARGET = 128
) (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  input  logic clr_i,
  input  logic strobe_i,
  input  logic bit_i,
  output logic done_o
);

  localparam int BIT_W = $clog2(RUN_LEN);
  localparam int RUN_W = $clog2(RUN_TARGET + 1);

  logic [BIT_W-1:0] bit_q;
  logic [RUN_W-1:0] runs_q;
  logic             run_end;

  assign run_end = (bit_q == BIT_W'(RUN_LEN - 1));
  assign done_o  = (runs_q == RUN_W'(RUN_TARGET));

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      bit_q  <= '0;
      runs_q <= '0;
    end else if (en_i && strobe_i) begin
      if (!bit_i) begin
        bit_q <= '0;
      end else if (run_end) begin
        bit_q <= '0;
        if (!done_o) begin
          runs_q <= runs_q + 1'b1;
        end
      end else begin
        bit_q <= bit_q + 1'b1;
      end
    end
  end

  // R4: a dominant bit discards the partial run
  a_r4_restart: assert property (@(posedge clk) disable iff (rst)
    (en_i && strobe_i && !bit_i) |=> bit_q == '0);

  // R4: run length never exceeds its bound
  a_r4_bit_range: assert property (@(posedge clk) disable iff (rst)
    bit_q < BIT_W'(RUN_LEN));

  // R5: credited runs saturate at the quota
  a_r5_run_cap: assert property (@(posedge clk) disable iff (rst)
    runs_q <= RUN_W'(RUN_TARGET));

  // R9: no progress while disabled
  a_r9_runs_hold: assert property (@(posedge clk) disable iff (rst)
    (!en_i && !clr_i) |=> $stable(runs_q));

endmodule

// File: rtl/bor_state_ctl.sv
module bor_state_ctl
  import bor_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        ovf_next_i,
  input  logic        done_i,
  input  logic        auto_i,
  input  logic        req_i,
  output node_state_t state_o,
  output logic        inhibit_o,
  output logic        ev_en_o,
  output logic        run_en_o,
  output logic        clr_o
);

  node_state_t state_q;
  node_state_t state_d;
  logic        inhibit_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      NODE_ACTIVE:  if (ovf_next_i) state_d = NODE_BUSOFF;
      NODE_BUSOFF:  if (done_i) state_d = auto_i ? NODE_ACTIVE : NODE_WAITREL;
      NODE_WAITREL: if (auto_i || req_i) state_d = NODE_ACTIVE;
      default:      state_d = NODE_ACTIVE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= NODE_ACTIVE;
      inhibit_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      inhibit_q <= (state_d != NODE_ACTIVE);
    end
  end

  assign state_o   = state_q;
  assign inhibit_o = inhibit_q;
  assign ev_en_o   = (state_q == NODE_ACTIVE);
  assign run_en_o  = (state_q == NODE_BUSOFF);
  assign clr_o     = (state_q != NODE_ACTIVE) && (state_d == NODE_ACTIVE);

  // R3: overflow while active leads to bus-off
  a_r3_enter: assert property (@(posedge clk) disable iff (rst)
    (state_q == NODE_ACTIVE && ovf_next_i) |=> state_q == NODE_BUSOFF);

  // R8: no exit before the sequence completes
  a_r8_no_early: assert property (@(posedge clk) disable iff (rst)
    (state_q == NODE_BUSOFF && !done_i) |=> state_q == NODE_BUSOFF);

  // R7: waiting state holds until released
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    (state_q == NODE_WAITREL && !auto_i && !req_i) |=> state_q == NODE_WAITREL);

  // R7: release from waiting state
  a_r7_release: assert property (@(posedge clk) disable iff (rst)
    (state_q == NODE_WAITREL && (auto_i || req_i)) |=> state_q == NODE_ACTIVE);

  // R11: inhibit tracks the node state
  a_r11_inhibit: assert property (@(posedge clk) disable iff (rst)
    inhibit_q == (state_q != NODE_ACTIVE));

endmodule

// File: rtl/busoff_supervisor.sv
module busoff_supervisor #(
  parameter int LIMIT      = 255,
  parameter int INC_STEP   = 8,
  parameter int DEC_STEP   = 1,
  parameter int RUN_LEN    = 11,
  parameter int RUN_TARGET = 128
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       err_inc_i,
  input  logic       err_dec_i,
  input  logic       bus_bit_i,
  input  logic       bit_strobe_i,
  input  logic       auto_rec_i,
  input  logic       rec_req_i,
  output logic [1:0] node_state_o,
  output logic       tx_inhibit_o
);

  import bor_pkg::*;

  node_state_t state;
  logic        ev_en;
  logic        run_en;
  logic        clr;
  logic        ovf_next;
  logic        done;

  bor_err_counter #(
    .LIMIT    (LIMIT),
    .INC_STEP (INC_STEP),
    .DEC_STEP (DEC_STEP)
  ) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .en_i       (ev_en),
    .clr_i      (clr),
    .inc_i      (err_inc_i),
    .dec_i      (err_dec_i),
    .ovf_next_o (ovf_next)
  );

  bor_run_tracker #(
    .RUN_LEN    (RUN_LEN),
    .RUN_TARGET (RUN_TARGET)
  ) u_runs (
    .clk      (clk),
    .rst      (rst),
    .en_i     (run_en),
    .clr_i    (clr),
    .strobe_i (bit_strobe_i),
    .bit_i    (bus_bit_i),
    .done_o   (done)
  );

  bor_state_ctl u_ctl (
    .clk        (clk),
    .rst        (rst),
    .ovf_next_i (ovf_next),
    .done_i     (done),
    .auto_i     (auto_rec_i),
    .req_i      (rec_req_i),
    .state_o    (state),
    .inhibit_o  (tx_inhibit_o),
    .ev_en_o    (ev_en),
    .run_en_o   (run_en),
    .clr_o      (clr)
  );

  assign node_state_o = state;

endmodule

// File: tb/tb_busoff_supervisor.sv
module tb_busoff_supervisor;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;
  localparam int SEQ_BITS   = 11 * 128;

  // vector: {reset, n_inc[7:0], n_dec[7:0], n_both[7:0], exp_state[1:0]}
  localparam int NV = 10;
  localparam logic [26:0] VEC [0:NV-1] = '{
    {1'b1, 8'd31, 8'd0,  8'd0,  2'd0},
    {1'b0, 8'd1,  8'd0,  8'd0,  2'd1},
    {1'b1, 8'd0,  8'd40, 8'd0,  2'd0},
    {1'b0, 8'd31, 8'd0,  8'd0,  2'd0},
    {1'b0, 8'd1,  8'd0,  8'd0,  2'd1},
    {1'b1, 8'd31, 8'd8,  8'd2,  2'd1},
    {1'b1, 8'd0,  8'd0,  8'd31, 2'd0},
    {1'b0, 8'd0,  8'd1,  8'd0,  2'd0},
    {1'b0, 8'd1,  8'd0,  8'd0,  2'd0},
    {1'b0, 8'd1,  8'd0,  8'd0,  2'd1}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic err_inc_i = 1'b0;
  logic err_dec_i = 1'b0;
  logic bus_bit_i = 1'b1;
  logic bit_strobe_i = 1'b0;
  logic auto_rec_i = 1'b1;
  logic rec_req_i = 1'b0;
  logic [1:0] node_state_o;
  logic tx_inhibit_o;

  int checks = 0;
  int errors = 0;

  busoff_supervisor dut (
    .clk          (clk),
    .rst          (rst),
    .err_inc_i    (err_inc_i),
    .err_dec_i    (err_dec_i),
    .bus_bit_i    (bus_bit_i),
    .bit_strobe_i (bit_strobe_i),
    .auto_rec_i   (auto_rec_i),
    .rec_req_i    (rec_req_i),
    .node_state_o (node_state_o),
    .tx_inhibit_o (tx_inhibit_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic drive(input logic inc, input logic dec, input logic bitv,
                       input logic strb, input logic req);
    @(negedge clk);
    err_inc_i    = inc;
    err_dec_i    = dec;
    bus_bit_i    = bitv;
    bit_strobe_i = strb;
    rec_req_i    = req;
  endtask

  task automatic idle();
    drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    err_inc_i = 1'b0; err_dec_i = 1'b0; bit_strobe_i = 1'b0; rec_req_i = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic recessive(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
  endtask

  task automatic incs(input int n);
    for (int i = 0; i < n; i++) drive(1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic check(input string req, input logic [1:0] exp_state);
    logic exp_inh;
    exp_inh = (exp_state != 2'd0);
    checks++;
    if (node_state_o !== exp_state || tx_inhibit_o !== exp_inh) begin
      errors++;
      $display("FAIL %s state=%0d inhibit=%0d expected state=%0d inhibit=%0d",
               req, node_state_o, tx_inhibit_o, exp_state, exp_inh);
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1 reset state
    do_reset();
    idle();
    check("R1 reset", 2'd0);

    // table: R2 arithmetic, R3 threshold
    for (int v = 0; v < NV; v++) begin
      if (VEC[v][26]) do_reset();
      for (int i = 0; i < int'(VEC[v][25:18]); i++) drive(1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
      for (int i = 0; i < int'(VEC[v][17:10]); i++) drive(1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
      for (int i = 0; i < int'(VEC[v][9:2]);   i++) drive(1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
      idle();
      check("R2/R3 table", VEC[v][1:0]);
    end

    // R9: strobes while active are not counted
    do_reset();
    auto_rec_i = 1'b1;
    recessive(SEQ_BITS);
    incs(32);
    idle();
    check("R3 busoff entry", 2'd1);
    // R9: error events in bus-off ignored, mixed with the bits
    for (int i = 0; i < SEQ_BITS - 1; i++) drive(i[0], ~i[0], 1'b1, 1'b1, 1'b0);
    idle(); idle(); idle();
    check("R9/R5 one bit short", 2'd1);
    recessive(1);
    idle();
    check("R5 latency first cycle", 2'd1);
    idle();
    check("R6 auto release", 2'd0);

    // R10: counter restarted from zero
    incs(31);
    idle();
    check("R10 31 raises", 2'd0);
    incs(1);
    idle();
    check("R10 32nd raise", 2'd1);

    // R4: dominant bit breaks runs
    for (int k = 0; k < 200; k++) begin
      recessive(10);
      drive(1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    end
    idle(); idle();
    check("R4 broken runs", 2'd1);
    recessive(SEQ_BITS - 1);
    idle(); idle();
    check("R4 after restart short", 2'd1);
    recessive(1);
    idle(); idle();
    check("R4 full sequence", 2'd0);

    // R8 and R7: manual release
    auto_rec_i = 1'b0;
    incs(32);
    idle();
    check("R3 manual entry", 2'd1);
    recessive(600);
    drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
    idle();
    check("R8 early request", 2'd1);
    recessive(SEQ_BITS - 600);
    idle(); idle();
    check("R8/R7 waiting", 2'd2);
    repeat (5) idle();
    check("R7 holds", 2'd2);
    drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
    idle();
    check("R7 request release", 2'd0);

    // R7: switching to auto while waiting releases
    incs(32);
    recessive(SEQ_BITS);
    idle(); idle();
    check("R7 waiting again", 2'd2);
    @(negedge clk);
    auto_rec_i = 1'b1;
    idle();
    check("R7 auto while waiting", 2'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule